// File: doc/BRIEF.md
# Programmable Gain Amplifier Configuration Loader

This block is a run-once SPI master. After reset it waits for a start request. It then captures an 8-bit gain word and shifts it into a dual-channel programmable gain amplifier. When the word has been sent it releases the amplifier's chip select and raises a completion flag. That flag is meant to enable the downstream ADC capture logic. The flag stays set until the next reset, so the amplifier is configured exactly once.

The gain word holds two 4-bit codes: bits [7:4] select the channel B gain and bits [3:0] select the channel A gain. Each channel is set on its own to an inverting gain of magnitude 0, 1, 2, 5, 10, 20, 50 or 100. The word 8'h11 sets both channels to -1, which gives the widest input range. The word travels MSB first. A rotating register presents each bit on MOSI. A phase timer holds every SCK level for a parameterised number of system clocks, and a down-counting bit tally ends the loop.

The controller is a Moore machine with seven states:
- IDLE: chip select high. It moves to SETUP on `start_req` and loads the word and the tally.
- SETUP: chip select low, SCK low. It moves to SCK_LO after the hold time.
- SCK_LO: SCK low. It moves to SCK_HI after the hold time.
- SCK_HI: SCK high. It moves to CHECK after the hold time, rotating the word and decrementing the tally as it leaves.
- CHECK: one cycle with SCK low. It returns to SCK_LO while bits remain, and moves to RELEASE when the tally is zero.
- RELEASE: chip select high. It moves to DONE after the hold time.
- DONE: `cfg_done` is high. This state has no exit.

Top module: `pga_gain_loader`

## Requirements
- R1: While reset is asserted, `cs_n` is 1, `sck` is 0, `mosi` is 0 and `cfg_done` is 0.
- R2: Without `start_req` the block stays idle after reset. `cs_n` stays 1, `sck` stays 0 and `cfg_done` stays 0.
- R3: The gain word is captured in the cycle `start_req` is accepted. Later changes on `gain_word` do not alter the transferred bits.
- R4: Bit k of the word is transferred as bit WORD_W-1-k, MSB first, with one bit per rising SCK edge. The value transferred is the `mosi` level at each rising SCK edge. Bits [7:4] code channel B and bits [3:0] code channel A.
- R5: `mosi` changes only while `sck` is low. It is stable through every SCK high phase.
- R6: Every SCK high phase lasts exactly HOLD_CYC clocks. Every SCK low phase lasts at least HOLD_CYC clocks, and this includes the time from the `cs_n` fall to the first rise.
- R7: `cs_n` falls once before the first SCK rise and stays low through the last SCK fall. `sck` is never high while `cs_n` is high.
- R8: `cfg_done` rises only after `cs_n` has been high for at least one cycle. While `cfg_done` is high, `cs_n` is 1 and `sck` is 0.
- R9: Once set, `cfg_done` stays high until reset. Further `start_req` pulses cause no SCK or chip select activity.
- R10: A `start_req` pulse during a transfer is ignored, and the word sent is unchanged.
- R11: A transfer has exactly WORD_W rising SCK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to begin the one-time load |
| gain_word | input | WORD_W | Gain codes: [7:4] channel B, [3:0] channel A |
| cs_n | output | 1 | Active-low chip select to the amplifier |
| sck | output | 1 | Serial clock to the amplifier |
| mosi | output | 1 | Serial data to the amplifier, valid at the rising SCK edge |
| cfg_done | output | 1 | Sticky completion flag that enables ADC capture |

## Verification
The bench builds the block with WORD_W = 8 and HOLD_CYC = 3. A hold of 3 rather than the minimum of 2 means a timer that stops one cycle early or late shows up as a phase length error. With an 8-bit word, all 256 gain words can be swept, each after its own reset. This covers every bit pattern on MOSI, including all-zero, all-one and alternating words. For every word the bench also rewrites the `gain_word` input right after the start. For one word in four it fires a stray start in mid-transfer, and after completion it tries a restart.

// File: rtl/pga_loader_pkg.sv
package pga_loader_pkg;

    typedef enum logic [2:0] {
        LD_IDLE    = 3'd0,
        LD_SETUP   = 3'd1,
        LD_SCK_LO  = 3'd2,
        LD_SCK_HI  = 3'd3,
        LD_CHECK   = 3'd4,
        LD_RELEASE = 3'd5,
        LD_DONE    = 3'd6
    } ld_state_e;

    // Both channels at gain -1: the widest input range
    localparam logic [7:0] GAIN_BOTH_UNITY = 8'h11;

endpackage

// File: rtl/pga_phase_timer.sv
module pga_phase_timer #(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic last
);
    localparam int CW = $clog2(HOLD_CYC) + 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST_CNT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_CNT);
endmodule

// File: rtl/pga_bit_tally.sv
module pga_bit_tally #(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic zero
);
    localparam int TW = $clog2(WORD_W + 1);
    localparam logic [TW-1:0] FULL = TW'(WORD_W);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= FULL;
        end else if (step && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign zero = (left_q == '0);
endmodule

// File: rtl/pga_gain_rotator.sv
module pga_gain_rotator #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [WORD_W-1:0] word_in,
    output logic              msb
);
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_in;
        end else if (step) begin
            word_q <= {word_q[WORD_W-2:0], word_q[WORD_W-1]};
        end
    end

    assign msb = word_q[WORD_W-1];
endmodule

// File: rtl/pga_gain_loader.sv
module pga_gain_loader
    import pga_loader_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [WORD_W-1:0] gain_word,
    output logic              cs_n,
    output logic              sck,
    output logic              mosi,
    output logic              cfg_done
);
    ld_state_e state_q, state_n;
    logic      tmr_last;
    logic      bits_zero;
    logic      do_load;
    logic      do_step;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LD_IDLE:    if (start_req) state_n = LD_SETUP;
            LD_SETUP:   if (tmr_last)  state_n = LD_SCK_LO;
            LD_SCK_LO:  if (tmr_last)  state_n = LD_SCK_HI;
            LD_SCK_HI:  if (tmr_last)  state_n = LD_CHECK;
            LD_CHECK:   state_n = bits_zero ? LD_RELEASE : LD_SCK_LO;
            LD_RELEASE: if (tmr_last)  state_n = LD_DONE;
            LD_DONE:    state_n = LD_DONE;
            default:    state_n = LD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cs_n     = 1'b1;
        sck      = 1'b0;
        cfg_done = 1'b0;
        unique case (state_q)
            LD_IDLE:    cs_n = 1'b1;
            LD_SETUP:   cs_n = 1'b0;
            LD_SCK_LO:  cs_n = 1'b0;
            LD_SCK_HI:  begin cs_n = 1'b0; sck = 1'b1; end
            LD_CHECK:   cs_n = 1'b0;
            LD_RELEASE: cs_n = 1'b1;
            LD_DONE:    cfg_done = 1'b1;
            default:    cs_n = 1'b1;
        endcase
    end

    assign do_load = (state_q == LD_IDLE) && start_req;
    assign do_step = (state_q == LD_SCK_HI) && tmr_last;

    pga_phase_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_n != state_q),
        .last  (tmr_last)
    );

    pga_bit_tally #(.WORD_W(WORD_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (do_load),
        .step  (do_step),
        .zero  (bits_zero)
    );

    pga_gain_rotator #(.WORD_W(WORD_W)) u_rot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (do_load),
        .step    (do_step),
        .word_in (gain_word),
        .msb     (mosi)
    );
endmodule

// File: rtl/pga_loader_chk.sv
module pga_loader_chk #(
    parameter int HOLD_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic mosi,
    input logic cfg_done
);
    logic [15:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (sck) begin
            hi_run <= hi_run + 16'd1;
        end else begin
            hi_run <= '0;
        end
    end

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

    // R8
    done_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (cs_n && !sck));

    // R8
    done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(cs_n));

    // R5
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R7
    sck_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    // R6
    high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |-> (hi_run == 16'(HOLD_CYC)));
endmodule

bind pga_gain_loader pga_loader_chk #(.HOLD_CYC(HOLD_CYC)) u_loader_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .mosi     (mosi),
    .cfg_done (cfg_done)
);

// File: tb/test_pga_gain_loader.sv
module test_pga_gain_loader;
    localparam int W    = 8;
    localparam int HOLD = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_req = 1'b0;
    logic [W-1:0] gain_word = '0;
    logic         cs_n, sck, mosi, cfg_done;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    pga_gain_loader #(.WORD_W(W), .HOLD_CYC(HOLD)) i_pga_gain_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .gain_word (gain_word),
        .cs_n      (cs_n),
        .sck       (sck),
        .mosi      (mosi),
        .cfg_done  (cfg_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_word(input logic [W-1:0] w, input bit stray);
        logic [W-1:0] rx = '0;
        int rises = 0, cs_edges = 0, hi_run = 0, lo_run = 0;
        int mosi_err = 0, hi_err = 0, lo_err = 0, cs_err = 0, done_err = 0, idle_err = 0;
        bit prev_sck, prev_mosi, prev_cs, seen_done = 0;

        @(negedge clk);
        rst_n = 1'b0; start_req = 1'b0; gain_word = w;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk({cs_n, sck, mosi, cfg_done} == 4'b1000, "R1", {cs_n, sck, mosi, cfg_done}, 4'b1000);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!cs_n || sck || cfg_done) idle_err++;
        end
        // R2 idle without start
        chk(idle_err == 0, "R2", idle_err, 0);

        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        gain_word = ~w; // R3: must not matter any more
        prev_sck = sck; prev_mosi = mosi; prev_cs = cs_n;
        if (!cs_n) cs_edges = 1;
        if (!cs_n && !sck) lo_run = 1;
        for (int cyc = 0; cyc < 400; cyc++) begin
            start_req = (stray && cyc == 12); // R10 stray start
            @(negedge clk);
            if (sck && !prev_sck) begin
                rises++;
                rx = {rx[W-2:0], mosi};
                if (lo_run < HOLD) lo_err++;
                if (cs_n) cs_err++;
            end
            if (sck && prev_sck && mosi != prev_mosi) mosi_err++;
            if (!sck && prev_sck && hi_run != HOLD) hi_err++;
            if (sck && cs_n) cs_err++;
            if (cs_n != prev_cs) cs_edges++;
            if (sck) begin
                hi_run++; lo_run = 0;
            end else begin
                hi_run = 0;
                if (!cs_n) lo_run++;
            end
            if (cfg_done) begin
                seen_done = 1;
                if (!prev_cs || !cs_n || sck) done_err++;
                break;
            end
            prev_sck = sck; prev_mosi = mosi; prev_cs = cs_n;
        end
        start_req = 1'b0;
        // R4 / R3 / R10 word content, MSB first
        chk(rx == w, stray ? "R10" : "R4", rx, w);
        chk(rx == w, "R3", rx, w);
        // R11 edge count
        chk(rises == W, "R11", rises, W);
        // R5 data stable while SCK high
        chk(mosi_err == 0, "R5", mosi_err, 0);
        // R6 phase lengths
        chk(hi_err == 0 && lo_err == 0, "R6", hi_err + lo_err, 0);
        // R7 one fall and one rise of chip select, SCK only inside
        chk(cs_edges == 2 && cs_err == 0, "R7", cs_edges, 2);
        // R8 done after release
        chk(seen_done && done_err == 0, "R8", {seen_done, done_err[7:0]}, 9'h100);

        // R9 sticky done, restart ignored
        gain_word = ~w;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        done_err = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!cfg_done || !cs_n || sck) done_err++;
        end
        chk(done_err == 0, "R9", done_err, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < (1 << W); w++) begin
            run_word(W'(w), (w % 4) == 3);
        end
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule